// File: doc/BRIEF.md
# Mealy Trace Acceptor Monitor

This block watches a two-state Mealy machine from outside and decides, one step at a time, whether everything it has seen since reset is a behaviour that machine can really produce. At each clock where the letter strobe is high it takes one two-bit letter. The upper bit is the machine's input and the lower bit is the machine's output. The monitor produces no data. It exposes only its classification: an accept level and a one-cycle violation pulse.

Inside there are three states. Home and Busy mirror the two states of the observed machine, and both are accepting. Trap is the only non-accepting state and it absorbs every illegal step. The legal traces are the repetitions of this group: any number of 00 letters, then 11, then any number of 10 letters, then 00. A designer places the monitor next to the machine, or next to a model of it, and either stops on the violation pulse or samples accept at the end of a run.

Top module: `trace_acceptor_mon`

## Requirements
- R1: While reset is held and in the cycle after it is released, accept is 1 and violation is 0. The monitor starts in Home.
- R2: Bit 1 of a letter is the observed input and bit 0 is the observed output. Letter 01 is illegal in every state, so a valid 01 always leads to Trap.
- R3: In Home, a valid letter 00 keeps the monitor in Home and accept stays 1.
- R4: In Home, a valid letter 11 moves the monitor to Busy. In Busy, a valid letter 10 keeps it in Busy. Accept stays 1 in both cases.
- R5: In Busy, a valid letter 00 returns the monitor to Home and accept stays 1.
- R6: Any other valid letter leads to Trap, and accept is 0 from the clock edge that takes the letter. The illegal letters are 10 or 01 in Home, and 11 or 01 in Busy.
- R7: Violation is 1 for exactly one cycle, the cycle after the edge on which Trap is entered. It is 0 at all other times.
- R8: Trap is never left without a reset. Any further letters, legal or not, keep accept at 0 and raise no new violation.
- R9: A cycle where the letter strobe is low changes nothing, whatever the letter value.
- R10: Asserting reset returns the monitor from Trap to Home, and accept goes back to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| letter_vld | input | 1 | The letter is taken on this clock |
| letter | input | 2 | Bit 1 is the observed input, bit 0 is the observed output |
| accept | output | 1 | The trace seen since reset is legal |
| violation | output | 1 | One-cycle pulse when Trap is entered |

## Verification
Both results follow a letter by exactly one clock edge. Accept follows from the state register, and violation is a register loaded on the edge that enters Trap. The driver sets each letter at a falling edge and queues the expected accept and violation for the following rising edge. The monitor pops that entry a quarter period after the rising edge and compares it, so every comparison falls in the single cycle where the result is due. The bench also follows a Trap entry with further letters, which confirms that the pulse has dropped again.

// File: rtl/tda_pkg.sv
package tda_pkg;
  localparam int LETTER_W = 2;

  typedef enum logic [1:0] {
    ST_HOME = 2'd0,
    ST_BUSY = 2'd1,
    ST_TRAP = 2'd2
  } tda_state_e;

  // letter[1] = observed input, letter[0] = observed output
  function automatic tda_state_e tda_step(input tda_state_e cur,
                                          input logic [LETTER_W-1:0] ltr);
    tda_state_e nxt;
    nxt = ST_TRAP;
    unique case (cur)
      ST_HOME: begin
        if (ltr == 2'b00)      nxt = ST_HOME;
        else if (ltr == 2'b11) nxt = ST_BUSY;
      end
      ST_BUSY: begin
        if (ltr == 2'b10)      nxt = ST_BUSY;
        else if (ltr == 2'b00) nxt = ST_HOME;
      end
      default: nxt = ST_TRAP;
    endcase
    return nxt;
  endfunction
endpackage

// File: rtl/tda_next.sv
module tda_next
  import tda_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  tda_state_e          cur,
  input  logic                vld,
  input  logic [LETTER_W-1:0] ltr,
  output tda_state_e          nxt,
  output logic                trap_entry
);
  tda_state_e stepped;

  always_comb begin
    stepped = tda_step(cur, ltr);
    nxt = vld ? stepped : cur;
    trap_entry = (cur != ST_TRAP) && (nxt == ST_TRAP);
  end

  a_r2_bad_letter_traps: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && ltr == 2'b01) |-> nxt == ST_TRAP);
  a_r6_entry_needs_letter: assert property (@(posedge clk) disable iff (!rst_n)
    trap_entry |-> vld);
endmodule

// File: rtl/tda_state.sv
module tda_state
  import tda_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vld,
  input  tda_state_e nxt,
  output tda_state_e cur
);
  always_ff @(posedge clk) begin
    if (!rst_n) cur <= ST_HOME;
    else        cur <= nxt;
  end

  a_r8_trap_absorbs: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == ST_TRAP) |=> (cur == ST_TRAP));
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> $stable(cur));
endmodule

// File: rtl/tda_alarm.sv
module tda_alarm (
  input  logic clk,
  input  logic rst_n,
  input  logic trap_entry,
  output logic pulse
);
  always_ff @(posedge clk) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= trap_entry;
  end

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/trace_acceptor_mon.sv
module trace_acceptor_mon
  import tda_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                letter_vld,
  input  logic [LETTER_W-1:0] letter,
  output logic                accept,
  output logic                violation
);
  tda_state_e state_q;
  tda_state_e state_d;
  logic       trap_entry;

  tda_next u_next (
    .clk(clk), .rst_n(rst_n), .cur(state_q), .vld(letter_vld),
    .ltr(letter), .nxt(state_d), .trap_entry(trap_entry)
  );

  tda_state u_state (
    .clk(clk), .rst_n(rst_n), .vld(letter_vld), .nxt(state_d), .cur(state_q)
  );

  tda_alarm u_alarm (
    .clk(clk), .rst_n(rst_n), .trap_entry(trap_entry), .pulse(violation)
  );

  assign accept = (state_q != ST_TRAP);

  a_r6_accept_drops: assert property (@(posedge clk) disable iff (!rst_n)
    trap_entry |=> !accept);
  a_r7_pulse_means_reject: assert property (@(posedge clk) disable iff (!rst_n)
    violation |-> !accept);
endmodule

// File: tb/test_trace_acceptor_mon.sv
`timescale 1ns/1ps
module test_trace_acceptor_mon;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       letter_vld = 1'b0;
  logic [1:0] letter = 2'b00;
  logic       accept;
  logic       violation;

  int checks = 0;
  int errors = 0;
  int model = 0;  // 0 home, 1 busy, 2 trap
  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  trace_acceptor_mon i_trace_acceptor_mon (
    .clk(clk), .rst_n(rst_n), .letter_vld(letter_vld), .letter(letter),
    .accept(accept), .violation(violation)
  );

  task automatic compare(input string tag, input logic a, input logic v);
    checks++;
    if (accept !== a || violation !== v) begin
      errors++;
      $display("FAIL %s accept/violation actual %b/%b expected %b/%b",
               tag, accept, violation, a, v);
    end
  endtask

  // driver: one letter per cycle, expected result queued for the next edge
  task automatic send(input logic vld, input logic [1:0] l, input string tag);
    int nm;
    logic entered;
    @(negedge clk);
    letter_vld = vld;
    letter = l;
    nm = model;
    if (vld) begin
      if (model == 0)      nm = (l == 2'b00) ? 0 : (l == 2'b11) ? 1 : 2;
      else if (model == 1) nm = (l == 2'b10) ? 1 : (l == 2'b00) ? 0 : 2;
      else                 nm = 2;
    end
    entered = (model != 2) && (nm == 2);
    model = nm;
    exp_q.push_back({model != 2, entered});
    tag_q.push_back(tag);
  endtask

  // monitor: pops one expectation a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        compare(t, e[1], e[0]);
      end
    end
  end

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n = 1'b0;
    letter_vld = 1'b0;
    model = 0;
    @(negedge clk);
    @(negedge clk);
    compare({tag, " during reset"}, 1'b1, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    compare({tag, " after release"}, 1'b1, 1'b0);
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired, actual hung expected done");
    finish_run();
  end

  initial begin
    do_reset("R1");

    // legal trace from the requirements: R3 R4 R5
    send(1, 2'b00, "R3 home 00");
    send(1, 2'b00, "R3 home 00");
    send(1, 2'b11, "R4 home 11");
    send(1, 2'b10, "R4 busy 10");
    send(1, 2'b10, "R4 busy 10");
    send(1, 2'b10, "R4 busy 10");
    send(1, 2'b00, "R5 busy 00");
    send(1, 2'b11, "R4 home 11");

    // 00 then 01 is rejected: R2 R6 R7, then trap holds: R8
    do_reset("R10 from busy");
    send(1, 2'b00, "R3 home 00");
    send(1, 2'b01, "R2 home 01");
    send(1, 2'b00, "R8 trap 00");
    send(1, 2'b11, "R8 trap 11");
    send(1, 2'b01, "R8 trap 01");
    do_reset("R10 from trap");

    // idle cycles ignored: R9
    send(0, 2'b01, "R9 idle 01");
    send(0, 2'b10, "R9 idle 10");
    send(1, 2'b11, "R4 home 11");
    send(0, 2'b00, "R9 idle 00 in busy");
    send(0, 2'b01, "R9 idle 01 in busy");
    send(1, 2'b11, "R6 busy 11");
    send(0, 2'b00, "R9 idle in trap");

    // remaining illegal steps: R6 R2
    do_reset("R10");
    send(1, 2'b10, "R6 home 10");
    send(1, 2'b10, "R8 trap 10");
    do_reset("R10");
    send(1, 2'b11, "R4 home 11");
    send(1, 2'b01, "R2 busy 01");
    send(1, 2'b00, "R8 trap 00");
    do_reset("R10");
    send(1, 2'b11, "R4 home 11");
    send(1, 2'b00, "R5 busy 00");
    send(1, 2'b00, "R3 home 00");

    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule